// File: doc/BRIEF.md
# Dimmer Conduction Angle Reference Processor

This block turns a phase-cut dimmer's conduction into a digital LED current reference. It watches a one-bit detect signal that is high while the scaled, rectified line voltage sits above a threshold. It also watches a marker pulse that arrives at each boundary of a rectified half-period. From these it measures the fraction of each half-period during which the dimmer conducts. Both the conduction time and the elapsed time are summed over two consecutive half-periods, so a triac that fires unevenly on the two line polarities still gives one steady figure.

The raw fraction comes from a sequential divider and passes through a first-order smoothing filter. It reaches the output only after a lockout of a set number of half-periods, which suppresses flicker from jittery firing edges. The held angle then goes through one of two piecewise-linear brightness curves, chosen by a select input. The result is an 8-bit reference code plus a flag that says whether dimming is in effect. With no dimmer present the reference sits at full scale and the flag is low.

Top module: `dim_angle_ref`

## Requirements
- R1: After a synchronous reset, `ref_code` is 255, `dimmed` is 0, and the internal filtered and held angle codes are 255.
- R2: A measurement window starts at the first `half_mark` after reset and spans two half-periods. The window closes at every second mark after that, and the closing mark also opens the next window. In a window, the on-count is the number of cycles with `tick` and `dim_hi` both high, and the span-count is the number of cycles with `tick` high. Each count includes the cycle of the mark that opens the window and excludes the cycle of the mark that closes it. Cycles without `tick` count toward neither.
- R3: The angle code of a window is floor(256 × on / span), or 255 when on ≥ span. A code c stands for c × 180/256 degrees.
- R4: At each window close the filtered angle y becomes y + floor((x − y)/4), where x is the new angle code. It changes at no other time.
- R5: Every `half_mark` increments a lockout count that saturates. At a window close, the held angle takes the new filtered value only if that count has reached LOCK_HALVES, and the count then clears. `ref_code` and `dimmed` change only when the held angle is taken.
- R6: When the held angle code is at least FULL_CODE (default 248), `ref_code` is 255 and `dimmed` is 0. Otherwise `dimmed` is 1.
- R7: With `curve_sel` = 0, the points (degrees, per-mille) are (18,0), (54,150), (72,350), (90,550), (108,755), (126,955), (130,1000) and (170,1000). A point's code is floor(deg × 256/180) and its level is floor((pm × 255 + 500)/1000). The output is 0 below the first point, the last level above the last point, and a linear interpolation in between, accurate to within 1 LSB.
- R8: With `curve_sel` = 1, the points are (18,0), (72,100), (90,280), (108,500), (126,750), (130,800), (140,950) and (144,1000), handled in the same way as in R7.
- R9: `curve_sel` is sampled only when a new held angle is taken. Changing it between those times leaves `ref_code` unchanged.
- R10: When the two half-periods of a window carry different conduction times, the angle follows their sum, so that for example 150 and 50 of 200 cycles give the same code as 100 and 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable; counters advance only when high |
| dim_hi | input | 1 | Dimmer-detect level, high while the line voltage exceeds the threshold |
| half_mark | input | 1 | One-cycle pulse at each rectified half-period boundary |
| curve_sel | input | 1 | Brightness curve select: 0 default, 1 alternate |
| ref_code | output | 8 | Current reference, 255 = 100 % |
| dimmed | output | 1 | High while a dimmer is cutting the conduction angle |

## Verification
The bench builds the block with LOCK_HALVES = 4 in place of 32, which puts an apply every second window. This brings both the held and the updated windows, and the whole filter settling, within a few thousand cycles. FULL_CODE stays at 248, so the near-full-scale cut-off is exercised at its real value. Half-periods of 200 ticks give angle codes fine enough to land on every curve segment. A slowed `tick` shows that the counts follow the time base rather than the clock.

// File: rtl/dimref_pkg.sv
package dimref_pkg;

    localparam int CNT_W  = 20;
    localparam int FRAC_W = 8;
    localparam int NPT    = 8;

    typedef struct packed {
        logic [CNT_W-1:0] on_cnt;
        logic [CNT_W-1:0] span_cnt;
    } win_meas_t;

    typedef enum logic {DIV_IDLE, DIV_RUN} div_state_e;

    function automatic int pt_deg(input bit alt, input int i);
        int d;
        if (!alt) begin
            case (i)
                0: d = 18;  1: d = 54;  2: d = 72;  3: d = 90;
                4: d = 108; 5: d = 126; 6: d = 130; default: d = 170;
            endcase
        end else begin
            case (i)
                0: d = 18;  1: d = 72;  2: d = 90;  3: d = 108;
                4: d = 126; 5: d = 130; 6: d = 140; default: d = 144;
            endcase
        end
        return d;
    endfunction

    function automatic int pt_pm(input bit alt, input int i);
        int p;
        if (!alt) begin
            case (i)
                0: p = 0;   1: p = 150; 2: p = 350; 3: p = 550;
                4: p = 755; 5: p = 955; default: p = 1000;
            endcase
        end else begin
            case (i)
                0: p = 0;   1: p = 100; 2: p = 280; 3: p = 500;
                4: p = 750; 5: p = 800; 6: p = 950; default: p = 1000;
            endcase
        end
        return p;
    endfunction

    function automatic int deg_to_code(input int d);
        return (d * 256) / 180;
    endfunction

    function automatic int pm_to_level(input int p);
        return (p * 255 + 500) / 1000;
    endfunction

endpackage

// File: rtl/win_timer.sv
module win_timer
    import dimref_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      dim_hi,
    input  logic      half_mark,
    output logic      win_done,
    output win_meas_t win,
    output logic      mark_seen
);
    logic             synced;
    logic             second_half;
    logic [CNT_W-1:0] on_acc;
    logic [CNT_W-1:0] span_acc;
    logic             inc_on;
    logic             inc_span;

    assign inc_on   = tick & dim_hi;
    assign inc_span = tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            synced      <= 1'b0;
            second_half <= 1'b0;
            on_acc      <= '0;
            span_acc    <= '0;
            win_done    <= 1'b0;
            win         <= '0;
            mark_seen   <= 1'b0;
        end else begin
            win_done  <= 1'b0;
            mark_seen <= half_mark;
            if (half_mark && (!synced || second_half)) begin
                if (synced) begin
                    win.on_cnt   <= on_acc;
                    win.span_cnt <= span_acc;
                    win_done     <= 1'b1;
                end
                synced      <= 1'b1;
                second_half <= 1'b0;
                on_acc      <= CNT_W'(inc_on);
                span_acc    <= CNT_W'(inc_span);
            end else if (synced) begin
                if (half_mark) second_half <= 1'b1;
                if (on_acc != '1)   on_acc   <= on_acc + CNT_W'(inc_on);
                if (span_acc != '1) span_acc <= span_acc + CNT_W'(inc_span);
            end
        end
    end

    a_r2_on_le_span: assert property (@(posedge clk) disable iff (rst)
        win_done |-> (win.on_cnt <= win.span_cnt));

    a_r2_idle_before_sync: assert property (@(posedge clk) disable iff (rst)
        !synced |-> (span_acc == '0 && !win_done));
endmodule

// File: rtl/ratio_div.sv
module ratio_div
    import dimref_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  win_meas_t         win,
    output logic              done,
    output logic [FRAC_W-1:0] quo
);
    localparam int SW = $clog2(FRAC_W + 1);

    div_state_e       state;
    logic [CNT_W-1:0] num;
    logic [CNT_W-1:0] den;
    logic [CNT_W-1:0] rem;
    logic             sat;
    logic [SW-1:0]    step;
    logic [CNT_W:0]   r2;
    logic             ge;

    assign r2 = {rem, 1'b0};
    assign ge = (r2 >= {1'b0, den});

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DIV_IDLE;
            num   <= '0;
            den   <= '0;
            rem   <= '0;
            sat   <= 1'b0;
            step  <= '0;
            quo   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                DIV_IDLE: if (start) begin
                    num   <= win.on_cnt;
                    den   <= win.span_cnt;
                    rem   <= win.on_cnt;
                    sat   <= (win.on_cnt >= win.span_cnt);
                    quo   <= '0;
                    step  <= '0;
                    state <= DIV_RUN;
                end
                default: begin
                    if (sat) begin
                        quo   <= '1;
                        done  <= 1'b1;
                        state <= DIV_IDLE;
                    end else begin
                        rem  <= ge ? CNT_W'(r2 - {1'b0, den}) : CNT_W'(r2);
                        quo  <= {quo[FRAC_W-2:0], ge};
                        step <= step + 1'b1;
                        if (step == SW'(FRAC_W - 1)) begin
                            done  <= 1'b1;
                            state <= DIV_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    a_r3_quot_bound: assert property (@(posedge clk) disable iff (rst)
        done |-> (({{CNT_W{1'b0}}, quo} * {{FRAC_W{1'b0}}, den}) <= {num, {FRAC_W{1'b0}}}));
endmodule

// File: rtl/ang_filter.sv
module ang_filter
    import dimref_pkg::*;
#(
    parameter int LOCK_HALVES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mark,
    input  logic              upd,
    input  logic [FRAC_W-1:0] x,
    output logic [FRAC_W-1:0] held,
    output logic              apply
);
    localparam int LW = $clog2(LOCK_HALVES + 1);

    logic        [FRAC_W-1:0] y;
    logic        [LW-1:0]     lock_cnt;
    logic signed [FRAC_W+1:0] diff;
    logic signed [FRAC_W+1:0] y_sum;
    logic        [FRAC_W-1:0] y_nx;
    logic                     lock_ok;

    assign diff    = $signed({2'b00, x}) - $signed({2'b00, y});
    assign y_sum   = $signed({2'b00, y}) + (diff >>> 2);
    assign y_nx    = FRAC_W'(y_sum);
    assign lock_ok = (lock_cnt >= LW'(LOCK_HALVES));

    always_ff @(posedge clk) begin
        if (rst) begin
            y        <= '1;
            held     <= '1;
            lock_cnt <= '0;
            apply    <= 1'b0;
        end else begin
            apply <= 1'b0;
            if (mark && !lock_ok) lock_cnt <= lock_cnt + 1'b1;
            if (upd) begin
                y <= y_nx;
                if (lock_ok) begin
                    held     <= y_nx;
                    apply    <= 1'b1;
                    lock_cnt <= '0;
                end
            end
        end
    end

    a_r4_step_toward: assert property (@(posedge clk) disable iff (rst)
        upd |=> ((y >= $past(y) && y <= $past(x)) || (y <= $past(y) && y >= $past(x))));

    a_r4_quiet_without_update: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(y));

    a_r5_held_only_on_apply: assert property (@(posedge clk) disable iff (rst)
        !$stable(held) |-> apply);
endmodule

// File: rtl/curve_map.sv
module curve_map
    import dimref_pkg::*;
(
    input  logic [FRAC_W-1:0] angle,
    input  logic              alt,
    output logic [FRAC_W-1:0] level
);
    localparam int XLD = deg_to_code(pt_deg(1'b0, NPT-1));
    localparam int XLA = deg_to_code(pt_deg(1'b1, NPT-1));
    localparam int YLD = pm_to_level(pt_pm(1'b0, NPT-1));
    localparam int YLA = pm_to_level(pt_pm(1'b1, NPT-1));

    logic [NPT-2:0]        seg_on;
    logic [FRAC_W-1:0]     seg_val [NPT-1];
    logic [FRAC_W-1:0]     x_last;
    logic [FRAC_W-1:0]     y_last;

    generate
        for (genvar i = 0; i < NPT-1; i++) begin : g_seg
            localparam int X0D = deg_to_code(pt_deg(1'b0, i));
            localparam int X1D = deg_to_code(pt_deg(1'b0, i+1));
            localparam int Y0D = pm_to_level(pt_pm(1'b0, i));
            localparam int Y1D = pm_to_level(pt_pm(1'b0, i+1));
            localparam int X0A = deg_to_code(pt_deg(1'b1, i));
            localparam int X1A = deg_to_code(pt_deg(1'b1, i+1));
            localparam int Y0A = pm_to_level(pt_pm(1'b1, i));
            localparam int Y1A = pm_to_level(pt_pm(1'b1, i+1));
            localparam int SLD = ((Y1D - Y0D) * 256) / (X1D - X0D);
            localparam int SLA = ((Y1A - Y0A) * 256) / (X1A - X0A);

            logic [FRAC_W-1:0] x0;
            logic [FRAC_W-1:0] y0;
            logic [15:0]       slope;
            logic [23:0]       prod;
            logic [15:0]       frac_part;
            logic [15:0]       sum;

            assign x0        = alt ? FRAC_W'(X0A) : FRAC_W'(X0D);
            assign y0        = alt ? FRAC_W'(Y0A) : FRAC_W'(Y0D);
            assign slope     = alt ? 16'(SLA) : 16'(SLD);
            assign prod      = {16'b0, angle - x0} * {8'b0, slope};
            assign frac_part = 16'(prod >> 8);
            assign sum       = {8'b0, y0} + frac_part;
            assign seg_on[i]  = (angle >= x0);
            assign seg_val[i] = (sum > 16'd255) ? 8'hFF : sum[7:0];
        end
    endgenerate

    assign x_last = alt ? FRAC_W'(XLA) : FRAC_W'(XLD);
    assign y_last = alt ? FRAC_W'(YLA) : FRAC_W'(YLD);

    always_comb begin
        level = '0;
        for (int i = 0; i < NPT-1; i++) begin
            if (seg_on[i]) level = seg_val[i];
        end
        if (angle >= x_last) level = y_last;
    end
endmodule

// File: rtl/dim_angle_ref.sv
module dim_angle_ref
    import dimref_pkg::*;
#(
    parameter int LOCK_HALVES = 32,
    parameter int FULL_CODE   = 248
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              dim_hi,
    input  logic              half_mark,
    input  logic              curve_sel,
    output logic [FRAC_W-1:0] ref_code,
    output logic              dimmed
);
    win_meas_t         win;
    logic              win_done;
    logic              mark_seen;
    logic              div_done;
    logic [FRAC_W-1:0] angle_raw;
    logic [FRAC_W-1:0] angle_held;
    logic              apply;
    logic [FRAC_W-1:0] curve_level;
    logic              at_full;

    win_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .dim_hi    (dim_hi),
        .half_mark (half_mark),
        .win_done  (win_done),
        .win       (win),
        .mark_seen (mark_seen)
    );

    ratio_div u_div (
        .clk   (clk),
        .rst   (rst),
        .start (win_done),
        .win   (win),
        .done  (div_done),
        .quo   (angle_raw)
    );

    ang_filter #(.LOCK_HALVES(LOCK_HALVES)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .mark  (mark_seen),
        .upd   (div_done),
        .x     (angle_raw),
        .held  (angle_held),
        .apply (apply)
    );

    curve_map u_curve (
        .angle (angle_held),
        .alt   (curve_sel),
        .level (curve_level)
    );

    assign at_full = (angle_held >= FRAC_W'(FULL_CODE));

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_code <= '1;
            dimmed   <= 1'b0;
        end else if (apply) begin
            ref_code <= at_full ? '1 : curve_level;
            dimmed   <= !at_full;
        end
    end

    a_r5_ref_stable: assert property (@(posedge clk) disable iff (rst)
        !apply |=> ($stable(ref_code) && $stable(dimmed)));

    a_r6_full_scale: assert property (@(posedge clk) disable iff (rst)
        !dimmed |-> (ref_code == '1));
endmodule

// File: tb/test_dim_angle_ref.sv
module test_dim_angle_ref;
    localparam int LOCK = 4;
    localparam int FULL = 248;
    localparam int P    = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       dim_hi = 1'b0;
    logic       half_mark = 1'b0;
    logic       curve_sel = 1'b0;
    logic [7:0] ref_code;
    logic       dimmed;

    int n_tests = 0;
    int n_fail  = 0;

    int m_on, m_span, m_y, m_held, m_lock, m_ref;
    bit m_sync, m_second, m_dim;
    int tick_div = 1;
    int gcyc = 0;

    always #4 clk = ~clk;

    dim_angle_ref #(.LOCK_HALVES(LOCK), .FULL_CODE(FULL)) i_dim_angle_ref (
        .clk(clk), .rst(rst), .tick(tick), .dim_hi(dim_hi),
        .half_mark(half_mark), .curve_sel(curve_sel),
        .ref_code(ref_code), .dimmed(dimmed)
    );

    function automatic int b_deg(bit alt, int i);
        int t0[8] = '{18, 54, 72, 90, 108, 126, 130, 170};
        int t1[8] = '{18, 72, 90, 108, 126, 130, 140, 144};
        return alt ? t1[i] : t0[i];
    endfunction

    function automatic int b_pm(bit alt, int i);
        int t0[8] = '{0, 150, 350, 550, 755, 955, 1000, 1000};
        int t1[8] = '{0, 100, 280, 500, 750, 800, 950, 1000};
        return alt ? t1[i] : t0[i];
    endfunction

    function automatic int expect_ref(int a, bit alt);
        int r;
        if (a >= FULL) return 255;
        r = 0;
        for (int i = 0; i < 7; i++) begin
            int x0 = b_deg(alt, i) * 256 / 180;
            int x1 = b_deg(alt, i+1) * 256 / 180;
            int y0 = (b_pm(alt, i) * 255 + 500) / 1000;
            int y1 = (b_pm(alt, i+1) * 255 + 500) / 1000;
            if (a >= x0) r = y0 + ((y1 - y0) * (a - x0)) / (x1 - x0);
        end
        if (a >= b_deg(alt, 7) * 256 / 180) r = (b_pm(alt, 7) * 255 + 500) / 1000;
        return r;
    endfunction

    task automatic check_out(string tag);
        int diff;
        n_tests++;
        diff = int'(ref_code) - m_ref;
        if (dimmed !== m_dim || diff > 1 || diff < -1 || (!m_dim && diff != 0)) begin
            n_fail++;
            $display("FAIL %s: ref_code=%0d dimmed=%0d expected ref_code=%0d dimmed=%0d",
                     tag, ref_code, dimmed, m_ref, m_dim);
        end
    endtask

    task automatic close_window();
        int q;
        q = (m_on >= m_span) ? 255 : (m_on * 256) / m_span;
        m_y = m_y + ((q - m_y) >>> 2);
        if (m_lock >= LOCK) begin
            m_held = m_y;
            m_lock = 0;
            m_ref  = expect_ref(m_held, curve_sel);
            m_dim  = (m_held < FULL);
        end
    endtask

    task automatic drive_half(int on_len, string tag);
        bit closing = 1'b0;
        for (int k = 0; k < P; k++) begin
            int i_on, i_sp;
            @(negedge clk);
            if (closing && k == 20) check_out(tag);
            half_mark = (k == 0);
            dim_hi    = (k < on_len);
            tick      = (tick_div <= 1) ? 1'b1 : ((gcyc % tick_div) == 0);
            gcyc++;
            i_sp = tick ? 1 : 0;
            i_on = (tick && dim_hi) ? 1 : 0;
            if (k == 0) begin
                if (m_lock < 255) m_lock++;
                if (!m_sync || m_second) begin
                    if (m_sync) begin
                        closing = 1'b1;
                        close_window();
                    end
                    m_sync = 1'b1; m_second = 1'b0;
                    m_on = i_on;   m_span = i_sp;
                end else begin
                    m_second = 1'b1;
                    m_on += i_on;  m_span += i_sp;
                end
            end else if (m_sync) begin
                m_on += i_on;  m_span += i_sp;
            end
        end
    endtask

    task automatic window(int c1, int c2, string tag);
        drive_half(c1, tag);
        drive_half(c2, tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        n_tests++;
        if (ref_code !== 8'd255 || dimmed !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: ref_code=%0d dimmed=%0d expected ref_code=255 dimmed=0", ref_code, dimmed);
        end
    endtask

    task automatic t_full();
        for (int w = 0; w < 3; w++) window(P, P, "R6 no dimmer");
        for (int w = 0; w < 3; w++) window(197, 197, "R6 near full scale");
    endtask

    task automatic t_lockout();
        for (int w = 0; w < 4; w++) window(100, 100, "R5 lockout hold");
    endtask

    task automatic t_filter();
        for (int w = 0; w < 6; w++) window(60, 60, "R4 filter settle");
    endtask

    task automatic t_default_curve();
        curve_sel = 1'b0;
        for (int c = 20; c <= 180; c += 40)
            for (int w = 0; w < 4; w++) window(c, c, "R7 R3 default curve");
    endtask

    task automatic t_alt_curve();
        curve_sel = 1'b1;
        for (int c = 30; c <= 170; c += 35)
            for (int w = 0; w < 4; w++) window(c, c, "R8 alternate curve");
    endtask

    task automatic t_sel_hold();
        for (int w = 0; w < 4; w++) window(90, 90, "R9 settle");
        curve_sel = 1'b0;
        window(90, 90, "R9 select held");
        curve_sel = 1'b1;
        window(90, 90, "R9 select held");
        curve_sel = 1'b0;
        window(90, 90, "R9 select held");
    endtask

    task automatic t_asym();
        for (int w = 0; w < 6; w++) window(150, 50, "R10 asymmetric halves");
        for (int w = 0; w < 4; w++) window(30, 130, "R10 asymmetric halves");
    endtask

    task automatic t_tick();
        tick_div = 3;
        for (int w = 0; w < 6; w++) window(70, 70, "R2 slowed tick");
        tick_div = 1;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_y = 255; m_held = 255; m_ref = 255; m_lock = 0;
        m_dim = 1'b0; m_sync = 1'b0; m_second = 1'b0; m_on = 0; m_span = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_full();
        t_lockout();
        t_filter();
        t_default_curve();
        t_alt_curve();
        t_sel_hold();
        t_asym();
        t_tick();
        drive_half(0, "R2 final close");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule